// File: doc/BRIEF.md
# Wide Down-Counting Timer with Compare Event

This block is a down-counting timer whose count is twice the width of the bus that reaches it. With the default parameter the bus is 12 bits wide and the count is 24 bits. Software writes the low half of the start value first, and that write lands in a reload latch. A second write, to the counter-high address, loads the whole count in a single clock. The timer then decrements once on every clock in which `tick_i` is high.

When the count passes from zero to all ones, the timer raises a one-cycle underflow pulse. In free-running mode it reloads itself from the reload latch. In one-shot mode it wraps to all ones, keeps counting, and stays quiet until the next load. A separate compare value, also written as two halves, produces a one-cycle compare pulse the first time the count is strictly greater than the compare value after a load.

The control logic is a small state machine with three states:
- `ST_IDLE`: no load has happened since reset, and the count holds.
- `ST_RUN`: counting, with underflow events enabled.
- `ST_SPENT`: a one-shot run has already underflowed, so counting continues without events.

Its transitions are:
- *load*: from any state to `ST_RUN`.
- *wrap-free*: from `ST_RUN` back to `ST_RUN`, with a reload from the latch.
- *wrap-once*: from `ST_RUN` to `ST_SPENT`.

The compare detector has two states:
- `CS_ARMED`: set by *load*.
- `CS_DONE`: reached by *fire*, and also the state after reset.

Top module: `tmr24_cmp`

## Requirements
- R1: After reset the count, both latch halves and both compare halves read as zero, and `uf_o` and `cmp_o` are low.
- R2: A write to address 0 (count-low) stores the data in the low half of the reload latch only. The running count is unchanged.
- R3: A write to address 1 (count-high) loads the count with {written data, latch low half} at that clock edge. The same write stores the data in the latch high half.
- R4: Addresses 2 and 3 read and write the latch low and latch high halves directly. Writing address 3 leaves the count unchanged.
- R5: Reading address 0 returns count bits [HALF_W-1:0], and address 1 returns the upper half. Addresses 4 and 5 read back the compare low and high halves.
- R6: The count drops by exactly one on each clock edge with `tick_i` high after a load. It holds when `tick_i` is low, and it holds before the first load.
- R7: After loading value V with `tick_i` held high, `uf_o` is high for one cycle, V+1 edges after the load edge.
- R8: With `free_run_i` high, an underflow reloads the count from the reload latch, so a latch value L gives an underflow every L+1 ticks.
- R9: With `free_run_i` low, an underflow wraps the count to all ones and counting continues. No further underflow pulse occurs until the next load.
- R10: `cmp_o` pulses for one cycle on the edge after the first clock at which the count, taken as unsigned, exceeds the compare value. It pulses at most once per load and never before the first load.
- R11: A count-high write takes priority over a tick in the same cycle, so the loaded value is not decremented at the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address (0 count-low, 1 count-high, 2 latch-low, 3 latch-high, 4 compare-low, 5 compare-high) |
| wdata_i | input | HALF_W | Write data |
| rdata_o | output | HALF_W | Read data for `addr_i`, combinational, zero for unused addresses |
| tick_i | input | 1 | Count enable |
| free_run_i | input | 1 | 1 = reload from latch on underflow, 0 = one-shot |
| uf_o | output | 1 | Underflow pulse |
| cmp_o | output | 1 | Compare pulse |

## Verification
A wrong count is visible within one cycle, because both halves of the count can be read at any time. The bench therefore reads the count after each run and compares it with the value computed from the number of ticks applied. A state machine stuck in the wrong state shows up at the next wrap: a second underflow pulse in one-shot mode, or a missing reload in free-running mode. These appear at tick V+1 or 2V+2 after a load of V. A compare detector that fails to re-arm or to disarm shows up as a missing or repeated `cmp_o` pulse inside the same window.

// File: rtl/tmr24_pkg.sv
package tmr24_pkg;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_LAT_LO = 3'd2,
        A_LAT_HI = 3'd3,
        A_CMP_LO = 3'd4,
        A_CMP_HI = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } tmr_state_e;

    typedef enum logic {
        CS_DONE  = 1'b0,
        CS_ARMED = 1'b1
    } cmp_state_e;

endpackage

// File: rtl/tmr24_regs.sv
module tmr24_regs
    import tmr24_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int CW = 2 * HALF_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [CW-1:0]     latch_o,
    output logic [CW-1:0]     cmpv_o,
    output logic              load_o,
    output logic [CW-1:0]     load_val_o
);

    logic [HALF_W-1:0] lat_lo_q, lat_hi_q, cmp_lo_q, cmp_hi_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lat_lo_q <= '0;
            lat_hi_q <= '0;
            cmp_lo_q <= '0;
            cmp_hi_q <= '0;
        end else if (wr_i) begin
            case (addr_i)
                A_CNT_LO, A_LAT_LO: lat_lo_q <= wdata_i;
                A_CNT_HI, A_LAT_HI: lat_hi_q <= wdata_i;
                A_CMP_LO:           cmp_lo_q <= wdata_i;
                A_CMP_HI:           cmp_hi_q <= wdata_i;
                default:            ;
            endcase
        end
    end

    assign latch_o    = {lat_hi_q, lat_lo_q};
    assign cmpv_o     = {cmp_hi_q, cmp_lo_q};
    assign load_o     = wr_i && (addr_i == A_CNT_HI);
    assign load_val_o = {wdata_i, lat_lo_q};

    AST_LATLO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == A_CNT_LO) |=> (lat_lo_q == $past(wdata_i))); // R2
    AST_LATHI_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == A_LAT_HI) |=> (lat_hi_q == $past(wdata_i))); // R4

endmodule

// File: rtl/tmr24_core.sv
module tmr24_core
    import tmr24_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int CW = 2 * HALF_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [CW-1:0] latch_i,
    input  logic          tick_i,
    input  logic          free_run_i,
    output logic [CW-1:0] cnt_o,
    output logic          uf_o
);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          uf_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // next state, next count and event
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        uf_d    = 1'b0;
        if (load_i) begin
            state_d = ST_RUN;
            cnt_d   = load_val_i;
        end else if (tick_i) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        uf_d = 1'b1;
                        if (free_run_i) begin
                            cnt_d = latch_i;
                        end else begin
                            cnt_d   = '1;
                            state_d = ST_SPENT;
                        end
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_SPENT: cnt_d = cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

    // output registers
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            uf_o  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            uf_o  <= uf_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_LOAD_ATOMIC: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_q == $past(load_val_i))); // R3 R11
    AST_DECREMENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE && tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
    AST_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R6
    AST_FREE_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (uf_o && $past(free_run_i) && !$past(rst_i)) |-> (cnt_q == $past(latch_i))); // R8
    AST_SPENT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SPENT && $past(state_q) == ST_SPENT) |-> !uf_o); // R9

endmodule

// File: rtl/tmr24_cmpdet.sv
module tmr24_cmpdet
    import tmr24_pkg::*;
#(
    parameter int HALF_W = 12,
    localparam int CW = 2 * HALF_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cmpv_i,
    output logic          cmp_o
);

    cmp_state_e cst_q, cst_d;
    logic       fire;

    assign fire = (cst_q == CS_ARMED) && !load_i && (cnt_i > cmpv_i);

    always_comb begin
        cst_d = cst_q;
        unique case (cst_q)
            CS_ARMED: if (fire) cst_d = CS_DONE;
            CS_DONE:  ;
            default:  cst_d = CS_DONE;
        endcase
        if (load_i) cst_d = CS_ARMED;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cst_q <= CS_DONE;
        else       cst_q <= cst_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cmp_o <= 1'b0;
        else       cmp_o <= fire;
    end

    AST_CMP_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        cmp_o |=> !cmp_o); // R10
    AST_CMP_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        cmp_o |-> $past(cnt_i > cmpv_i)); // R10

endmodule

// File: rtl/tmr24_cmp.sv
module tmr24_cmp
    import tmr24_pkg::*;
#(
    parameter int HALF_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic [2:0]        addr_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] rdata_o,
    input  logic              tick_i,
    input  logic              free_run_i,
    output logic              uf_o,
    output logic              cmp_o
);

    localparam int CW = 2 * HALF_W;

    logic [CW-1:0] latch, cmpv, load_val, cnt;
    logic          load;

    tmr24_regs #(.HALF_W(HALF_W)) regs_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .latch_o    (latch),
        .cmpv_o     (cmpv),
        .load_o     (load),
        .load_val_o (load_val)
    );

    tmr24_core #(.HALF_W(HALF_W)) core_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .load_val_i (load_val),
        .latch_i    (latch),
        .tick_i     (tick_i),
        .free_run_i (free_run_i),
        .cnt_o      (cnt),
        .uf_o       (uf_o)
    );

    tmr24_cmpdet #(.HALF_W(HALF_W)) cmpdet_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .cnt_i  (cnt),
        .cmpv_i (cmpv),
        .cmp_o  (cmp_o)
    );

    always_comb begin
        case (addr_i)
            A_CNT_LO: rdata_o = cnt[HALF_W-1:0];
            A_CNT_HI: rdata_o = cnt[CW-1:HALF_W];
            A_LAT_LO: rdata_o = latch[HALF_W-1:0];
            A_LAT_HI: rdata_o = latch[CW-1:HALF_W];
            A_CMP_LO: rdata_o = cmpv[HALF_W-1:0];
            A_CMP_HI: rdata_o = cmpv[CW-1:HALF_W];
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: tb/tmr24_cmp_tb_top.sv
module tmr24_cmp_tb_top;
    import tmr24_pkg::*;

    localparam int HW         = 4;
    localparam int MAXV       = (1 << (2 * HW)) - 1;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1;
    logic          wr_i = 1'b0;
    logic [2:0]    addr_i = 3'd0;
    logic [HW-1:0] wdata_i = '0;
    logic [HW-1:0] rdata_o;
    logic          tick_i = 1'b0;
    logic          free_run_i = 1'b0;
    logic          uf_o, cmp_o;

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr24_cmp #(.HALF_W(HW)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i),
        .free_run_i(free_run_i), .uf_o(uf_o), .cmp_o(cmp_o)
    );

    task automatic chk(input int act, input int exp, input string tag);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input reg_addr_e a, input int d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = HW'(d);
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output int v);
        @(negedge clk);
        addr_i = a;
        #1 v = int'(rdata_o);
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(A_CNT_LO, lo);
        rd(A_CNT_HI, hi);
        v = hi * (1 << HW) + lo;
    endtask

    // one load of v with compare c, tick held high from the load cycle on (R11)
    task automatic run(input int v, input int c, input bit fr);
        int w, ufbad, cmpbad, got, expc;
        bit eu, ec;
        tick_i = 1'b0;
        free_run_i = fr;
        wr(A_CMP_LO, c % (1 << HW));
        wr(A_CMP_HI, c / (1 << HW));
        wr(A_CNT_LO, v % (1 << HW));
        @(negedge clk);
        wr_i = 1'b1; addr_i = A_CNT_HI; wdata_i = HW'(v / (1 << HW)); tick_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
        w = 2 * v + 4;
        ufbad = -1;
        cmpbad = -1;
        for (int k = 1; k <= w; k++) begin
            @(negedge clk);
            eu = fr ? ((k % (v + 1)) == 0) : (k == v + 1);
            ec = (v > c) ? (k == 1) : (!fr && c < MAXV && k == v + 2);
            if (uf_o !== eu && ufbad < 0) ufbad = k;
            if (cmp_o !== ec && cmpbad < 0) cmpbad = k;
        end
        tick_i = 1'b0;
        chk(ufbad, -1, $sformatf("%s R7 underflow first wrong cycle (v=%0d fr=%0d)", fr ? "R8" : "R9", v, fr));
        chk(cmpbad, -1, $sformatf("R10 compare first wrong cycle (v=%0d c=%0d fr=%0d)", v, c, fr));
        rd_cnt(got);
        if (fr) expc = v - (w % (v + 1));
        else    expc = (((v - w) % (MAXV + 1)) + MAXV + 1) % (MAXV + 1);
        chk(got, expc, $sformatf("R6 count after %0d ticks (v=%0d fr=%0d)", w, v, fr));
    endtask

    initial begin
        int val;
        int cvals[5] = '{0, 5, 100, 254, 255};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_i = 1'b0;

        // R1 reset state
        rd(A_CNT_LO, val); chk(val, 0, "R1 count low");
        rd(A_CNT_HI, val); chk(val, 0, "R1 count high");
        rd(A_LAT_LO, val); chk(val, 0, "R1 latch low");
        rd(A_LAT_HI, val); chk(val, 0, "R1 latch high");
        rd(A_CMP_LO, val); chk(val, 0, "R1 compare low");
        rd(A_CMP_HI, val); chk(val, 0, "R1 compare high");
        chk(int'(uf_o), 0, "R1 uf_o");
        chk(int'(cmp_o), 0, "R1 cmp_o");

        // R6 hold before first load
        tick_i = 1'b1;
        repeat (5) @(negedge clk);
        chk(int'(uf_o), 0, "R6 no underflow before load");
        tick_i = 1'b0;
        rd_cnt(val); chk(val, 0, "R6 count holds before load");

        // R2 count-low write goes to latch only
        wr(A_CNT_LO, 10);
        rd(A_LAT_LO, val); chk(val, 10, "R2 latch low");
        rd_cnt(val); chk(val, 0, "R2 count untouched");

        // R4 / R5 direct latch and compare access
        wr(A_LAT_HI, 3);
        rd(A_LAT_HI, val); chk(val, 3, "R4 latch high readback");
        wr(A_CMP_LO, 7);
        wr(A_CMP_HI, 9);
        rd(A_CMP_LO, val); chk(val, 7, "R5 compare low readback");
        rd(A_CMP_HI, val); chk(val, 9, "R5 compare high readback");

        // R3 atomic load
        wr(A_CNT_HI, 5);
        rd(A_CNT_LO, val); chk(val, 10, "R3 count low from latch");
        rd(A_CNT_HI, val); chk(val, 5, "R3 count high from data");
        rd(A_LAT_HI, val); chk(val, 5, "R3 latch high follows write");

        // R4 latch-high write leaves count alone
        wr(A_LAT_HI, 12);
        rd_cnt(val); chk(val, 16'h5A, "R4 count after latch-high write");
        rd(A_LAT_HI, val); chk(val, 12, "R4 latch high new value");

        // R6 exact tick count
        @(negedge clk); tick_i = 1'b1;
        repeat (3) @(negedge clk);
        tick_i = 1'b0;
        repeat (4) @(negedge clk);
        rd_cnt(val); chk(val, 16'h57, "R6 three ticks then hold");

        // sweep: R7 R8 R9 R10 R11
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 5; j++) begin
                run(i * 17, cvals[j], 1'b0);
                run(i * 17, cvals[j], 1'b1);
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule